// File: doc/BRIEF.md
# Cycle-Exact Reset Pulse Sequencer

This block drives the active-low reset input of a target device with single-clock precision, for studying how the target behaves while it boots. It runs from the same clock as the target, so every delay it produces is a whole number of target cycles. A run starts from a command strobe or from a debounced push button. The block first holds the target in reset for a programmed number of clocks and then lets it go. After a programmed offset it pulls reset low again for a programmed width, which can be a single clock. It then returns to idle.

To scan a range of offsets, the block can be armed in sweep mode. The offset then moves by a programmed step after every completed run until it would pass a stop value. At that point a done flag rises and further starts are refused.

The block also watches a small group of target status pins. Each time their synchronised value changes, it queues an entry into a small FIFO. The entry holds the new pin value and a 24-bit timestamp that counts clocks from the most recent reset release. Software or a serial transmitter drains the FIFO through a show-ahead read port. When the FIFO is full, new entries are discarded and a sticky overflow flag is raised.

Top module: `reset_pulse_sequencer`

## Requirements
- R1: After `rstN` is released, `targetRstN` is 1, `busy` is 0, `sweepDone` is 0, `fifoValid` is 0, `fifoFull` is 0 and `fifoOverflow` is 0.
- R2: An accepted start drives `targetRstN` low, beginning at the next clock edge, for exactly `holdCycles` clocks. A value of 0 is treated as 1.
- R3: After the hold, `targetRstN` stays high for exactly max(`curOffset`,1) clocks. It is then low for exactly max(`pulseWidth`,1) clocks, after which it returns high and `busy` drops in that same cycle. While `busy` is 0, `targetRstN` is 1.
- R4: The 24-bit timestamp is 0 in the first cycle after reset release and then rises by one every clock.
- R5: `offsetLoad` copies `offsetStart` into `curOffset` and clears `sweepDone`. After each completed run with `sweepEn` set, `curOffset` grows by `offsetStep`, unless the sum would exceed `offsetStop`. In that case `sweepDone` is set and `curOffset` is left unchanged.
- R6: A start request is ignored while `busy` is 1. It is also ignored while both `sweepEn` and `sweepDone` are 1.
- R7: `buttonIn` passes through two flip-flops. It is accepted only after the synchronised level has differed from the debounced level for DEBOUNCE_CYCLES consecutive clocks. A debounced rising edge starts a run: with the defaults, `targetRstN` first reads low 19 clocks after the button rises. Shorter bounces and the release have no effect.
- R8: Each change of the two-flop-synchronised `gpioIn` queues the entry {gpio, timestamp}. The gpio value sits in bits [GPIO_W+TS_W-1:TS_W] and the timestamp in bits [TS_W-1:0]. The recorded timestamp is the count in effect one clock after the edge that first samples the new pin value, which is two counts after the count current when the pin changed.
- R9: The FIFO is show-ahead: `fifoValid` is 1 whenever it holds an entry, `fifoData` shows the oldest entry, and `fifoPop` removes it. Entries leave in arrival order. A pop on an empty FIFO has no effect.
- R10: When FIFO_DEPTH entries are held, `fifoFull` is 1 and further changes are dropped. `fifoOverflow` becomes 1 and stays 1 until `rstN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the target |
| rstN | input | 1 | Active-low reset of this block |
| startReq | input | 1 | One-clock start command |
| buttonIn | input | 1 | Raw push-button level, asynchronous |
| holdCycles | input | CNT_W | Initial reset hold length in clocks |
| offsetStart | input | CNT_W | Offset loaded by `offsetLoad`; first sweep value |
| offsetStop | input | CNT_W | Highest offset a sweep may reach |
| offsetStep | input | CNT_W | Offset increment per completed sweep run |
| pulseWidth | input | CNT_W | Width of the second reset pulse in clocks |
| sweepEn | input | 1 | Advance the offset after each run |
| offsetLoad | input | 1 | Load `curOffset` from `offsetStart`, clear done |
| gpioIn | input | GPIO_W | Target status pins, asynchronous |
| fifoPop | input | 1 | Remove the oldest FIFO entry |
| targetRstN | output | 1 | Active-low reset driven to the target |
| busy | output | 1 | A run is in progress |
| sweepDone | output | 1 | The sweep has passed its stop value |
| curOffset | output | CNT_W | Offset used by the next run |
| fifoValid | output | 1 | FIFO holds at least one entry |
| fifoData | output | GPIO_W+TS_W | Oldest entry {gpio, timestamp} |
| fifoFull | output | 1 | FIFO holds FIFO_DEPTH entries |
| fifoOverflow | output | 1 | A change was dropped since reset |

## Verification
The run timing is exercised with directed minimum-length settings, where zeros collapse to single clocks, and with random hold, offset and width triples. Each measured low-high-low segment length shows whether a counter is off by one or a zero clamp is missing. Two sweeps are run, one that stops short of the stop value and one that lands on it exactly, which separates a strict comparison from a non-strict one. The button is tried with short bounces and then a clean press, so a debouncer that resets its counter wrongly, or counts the release as a start, shows up. The pin monitor is driven at known cycle positions inside a run, with random spacings in free time, and with more changes than the FIFO holds. These patterns check the absolute timestamp offset, the relative spacing, the ordering and the drop-on-full rule.

// File: rtl/rps_pkg.sv
package rps_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_GAP   = 2'd2,
    ST_PULSE = 2'd3
  } seqState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic tsClear;   // reset release happens on this edge
    logic inRun;     // a run is active (informational gate for monitor)
  } ctlStrobe_t;

endpackage

// File: rtl/rps_sync.sv
module rps_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/rps_debounce.sv
module rps_debounce #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic pressStb
);
  localparam int CW = $clog2(CYCLES + 1);

  logic          syncLvl;
  logic          stableLvl;
  logic [CW-1:0] diffCnt;

  rps_sync #(.W(1), .STAGES(2)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .d   (rawIn),
    .q   (syncLvl)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stableLvl <= 1'b0;
      diffCnt   <= '0;
      pressStb  <= 1'b0;
    end else begin
      pressStb <= 1'b0;
      if (syncLvl == stableLvl) begin
        diffCnt <= '0;
      end else if (diffCnt == CW'(CYCLES - 1)) begin
        stableLvl <= syncLvl;
        diffCnt   <= '0;
        pressStb  <= syncLvl;
      end else begin
        diffCnt <= diffCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rps_control.sv
module rps_control
  import rps_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             btnStart,
  input  logic [CNT_W-1:0] holdCycles,
  input  logic [CNT_W-1:0] offsetStart,
  input  logic [CNT_W-1:0] offsetStop,
  input  logic [CNT_W-1:0] offsetStep,
  input  logic [CNT_W-1:0] pulseWidth,
  input  logic             sweepEn,
  input  logic             offsetLoad,
  output logic             targetRstN,
  output logic             busy,
  output logic             sweepDone,
  output logic [CNT_W-1:0] curOffset,
  output ctlStrobe_t       strobes
);
  seqState_t        state;
  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] gapLen;
  logic [CNT_W-1:0] widthLen;
  logic             startAccept;
  logic             runEnd;
  logic [CNT_W:0]   nextSum;

  function automatic logic [CNT_W-1:0] atLeastOne(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  assign startAccept = (startReq || btnStart) && (state == ST_IDLE) && !(sweepEn && sweepDone);
  assign runEnd      = (state == ST_PULSE) && (phaseCnt == '0);
  assign nextSum     = {1'b0, curOffset} + {1'b0, offsetStep};

  always_comb begin
    strobes.tsClear = (state == ST_HOLD) && (phaseCnt == '0);
    strobes.inRun   = (state != ST_IDLE);
  end

  assign busy = (state != ST_IDLE);

  // run sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      phaseCnt   <= '0;
      gapLen     <= CNT_W'(1);
      widthLen   <= CNT_W'(1);
      targetRstN <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startAccept) begin
            state      <= ST_HOLD;
            phaseCnt   <= atLeastOne(holdCycles) - 1'b1;
            gapLen     <= atLeastOne(curOffset);
            widthLen   <= atLeastOne(pulseWidth);
            targetRstN <= 1'b0;
          end
        end
        ST_HOLD: begin
          if (phaseCnt == '0) begin
            state      <= ST_GAP;
            phaseCnt   <= gapLen - 1'b1;
            targetRstN <= 1'b1;
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        ST_GAP: begin
          if (phaseCnt == '0) begin
            state      <= ST_PULSE;
            phaseCnt   <= widthLen - 1'b1;
            targetRstN <= 1'b0;
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        ST_PULSE: begin
          if (phaseCnt == '0) begin
            state      <= ST_IDLE;
            targetRstN <= 1'b1;
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // offset sweep
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curOffset <= '0;
      sweepDone <= 1'b0;
    end else if (offsetLoad) begin
      curOffset <= offsetStart;
      sweepDone <= 1'b0;
    end else if (runEnd && sweepEn) begin
      if (nextSum > {1'b0, offsetStop}) sweepDone <= 1'b1;
      else                              curOffset <= nextSum[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/rps_datapath.sv
module rps_datapath
  import rps_pkg::*;
#(
  parameter int GPIO_W     = 4,
  parameter int TS_W       = 24,
  parameter int FIFO_DEPTH = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctlStrobe_t             strobes,
  input  logic [GPIO_W-1:0]      gpioIn,
  input  logic                   fifoPop,
  output logic                   fifoValid,
  output logic [GPIO_W+TS_W-1:0] fifoData,
  output logic                   fifoFull,
  output logic                   fifoOverflow,
  output logic [TS_W-1:0]        tsCount
);
  localparam int EW = GPIO_W + TS_W;
  localparam int AW = $clog2(FIFO_DEPTH);

  logic [GPIO_W-1:0] gpioSync;
  logic [GPIO_W-1:0] gpioPrev;
  logic              gpioChange;
  logic [EW-1:0]     mem [FIFO_DEPTH];
  logic [AW-1:0]     wrPtr;
  logic [AW-1:0]     rdPtr;
  logic [AW:0]       fill;
  logic              doPush;
  logic              doPop;

  // cycle timestamp, zeroed at target reset release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                tsCount <= '0;
    else if (strobes.tsClear) tsCount <= '0;
    else                      tsCount <= tsCount + 1'b1;
  end

  rps_sync #(.W(GPIO_W), .STAGES(2)) u_gpioSync (
    .clk (clk),
    .rstN(rstN),
    .d   (gpioIn),
    .q   (gpioSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gpioPrev <= '0;
    else       gpioPrev <= gpioSync;
  end

  assign gpioChange = (gpioSync != gpioPrev);
  assign fifoFull   = (fill == (AW+1)'(FIFO_DEPTH));
  assign fifoValid  = (fill != '0);
  assign doPush     = gpioChange && !fifoFull;
  assign doPop      = fifoPop && fifoValid;
  assign fifoData   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= {gpioSync, tsCount};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr        <= '0;
      rdPtr        <= '0;
      fill         <= '0;
      fifoOverflow <= 1'b0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
      if (gpioChange && fifoFull) fifoOverflow <= 1'b1;
    end
  end
endmodule

// File: rtl/reset_pulse_sequencer.sv
module reset_pulse_sequencer
  import rps_pkg::*;
#(
  parameter int CNT_W           = 16,
  parameter int GPIO_W          = 4,
  parameter int TS_W            = 24,
  parameter int FIFO_DEPTH      = 8,
  parameter int DEBOUNCE_CYCLES = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startReq,
  input  logic                   buttonIn,
  input  logic [CNT_W-1:0]       holdCycles,
  input  logic [CNT_W-1:0]       offsetStart,
  input  logic [CNT_W-1:0]       offsetStop,
  input  logic [CNT_W-1:0]       offsetStep,
  input  logic [CNT_W-1:0]       pulseWidth,
  input  logic                   sweepEn,
  input  logic                   offsetLoad,
  input  logic [GPIO_W-1:0]      gpioIn,
  input  logic                   fifoPop,
  output logic                   targetRstN,
  output logic                   busy,
  output logic                   sweepDone,
  output logic [CNT_W-1:0]       curOffset,
  output logic                   fifoValid,
  output logic [GPIO_W+TS_W-1:0] fifoData,
  output logic                   fifoFull,
  output logic                   fifoOverflow
);
  ctlStrobe_t      strobes;
  logic            btnStart;
  logic [TS_W-1:0] tsCount;

  rps_debounce #(.CYCLES(DEBOUNCE_CYCLES)) u_debounce (
    .clk     (clk),
    .rstN    (rstN),
    .rawIn   (buttonIn),
    .pressStb(btnStart)
  );

  rps_control #(.CNT_W(CNT_W)) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .btnStart   (btnStart),
    .holdCycles (holdCycles),
    .offsetStart(offsetStart),
    .offsetStop (offsetStop),
    .offsetStep (offsetStep),
    .pulseWidth (pulseWidth),
    .sweepEn    (sweepEn),
    .offsetLoad (offsetLoad),
    .targetRstN (targetRstN),
    .busy       (busy),
    .sweepDone  (sweepDone),
    .curOffset  (curOffset),
    .strobes    (strobes)
  );

  rps_datapath #(
    .GPIO_W    (GPIO_W),
    .TS_W      (TS_W),
    .FIFO_DEPTH(FIFO_DEPTH)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .gpioIn      (gpioIn),
    .fifoPop     (fifoPop),
    .fifoValid   (fifoValid),
    .fifoData    (fifoData),
    .fifoFull    (fifoFull),
    .fifoOverflow(fifoOverflow),
    .tsCount     (tsCount)
  );
endmodule

// File: rtl/rps_checker.sv
module rps_checker #(
  parameter int CNT_W = 16,
  parameter int TS_W  = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             targetRstN,
  input logic             busy,
  input logic             sweepDone,
  input logic             sweepEn,
  input logic             offsetLoad,
  input logic [CNT_W-1:0] curOffset,
  input logic             fifoValid,
  input logic             fifoFull,
  input logic             fifoOverflow,
  input logic [TS_W-1:0]  tsCount
);
  p_idle_released_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> targetRstN);

  p_ts_zero_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    busy && $rose(targetRstN) |-> tsCount == '0);

  p_ts_counts_r4: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(targetRstN) |-> tsCount == TS_W'($past(tsCount) + 1'b1));

  p_done_freezes_r5: assert property (@(posedge clk) disable iff (!rstN)
    sweepDone && !offsetLoad |=> $stable(curOffset) && sweepDone);

  p_done_blocks_r6: assert property (@(posedge clk) disable iff (!rstN)
    sweepEn && sweepDone && !busy && !offsetLoad |=> !busy);

  p_full_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> fifoValid);

  p_overflow_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    fifoOverflow |=> fifoOverflow);
endmodule

bind reset_pulse_sequencer rps_checker #(.CNT_W(CNT_W), .TS_W(TS_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .targetRstN  (targetRstN),
  .busy        (busy),
  .sweepDone   (sweepDone),
  .sweepEn     (sweepEn),
  .offsetLoad  (offsetLoad),
  .curOffset   (curOffset),
  .fifoValid   (fifoValid),
  .fifoFull    (fifoFull),
  .fifoOverflow(fifoOverflow),
  .tsCount     (tsCount)
);

// File: tb/reset_pulse_sequencer_tb.sv
module reset_pulse_sequencer_tb;
  localparam int CNT_W = 16;
  localparam int GW    = 4;
  localparam int TW    = 24;
  localparam int DEPTH = 8;
  localparam int DB    = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, buttonIn = 1'b0, sweepEn = 1'b0, offsetLoad = 1'b0, fifoPop = 1'b0;
  logic [CNT_W-1:0] holdCycles = '0, offsetStart = '0, offsetStop = '0, offsetStep = '0, pulseWidth = '0;
  logic [GW-1:0] gpioIn = '0;
  logic targetRstN, busy, sweepDone, fifoValid, fifoFull, fifoOverflow;
  logic [CNT_W-1:0] curOffset;
  logic [GW+TW-1:0] fifoData;

  int nTests = 0;
  int nFail  = 0;

  always #10 clk = ~clk;

  reset_pulse_sequencer #(
    .CNT_W(CNT_W), .GPIO_W(GW), .TS_W(TW), .FIFO_DEPTH(DEPTH), .DEBOUNCE_CYCLES(DB)
  ) u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .buttonIn(buttonIn),
    .holdCycles(holdCycles), .offsetStart(offsetStart), .offsetStop(offsetStop),
    .offsetStep(offsetStep), .pulseWidth(pulseWidth), .sweepEn(sweepEn),
    .offsetLoad(offsetLoad), .gpioIn(gpioIn), .fifoPop(fifoPop),
    .targetRstN(targetRstN), .busy(busy), .sweepDone(sweepDone), .curOffset(curOffset),
    .fifoValid(fifoValid), .fifoData(fifoData), .fifoFull(fifoFull), .fifoOverflow(fifoOverflow)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int atLeastOne(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic loadOffset(input int v);
    @(negedge clk);
    offsetStart = CNT_W'(v);
    offsetLoad  = 1'b1;
    @(negedge clk);
    offsetLoad  = 1'b0;
  endtask

  // start a run and measure low / high / low segment lengths at negedges
  task automatic runMeasure(input bit poke, output int h, output int o, output int w);
    int phase;
    bit v;
    h = 0; o = 0; w = 0; phase = 0;
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      startReq = (poke && (i == 2 || i == h + 1));
      v = targetRstN;
      if (phase == 0) begin
        if (!v) h++; else begin phase = 1; o++; end
      end else if (phase == 1) begin
        if (v) o++; else begin phase = 2; w++; end
      end else begin
        if (!v) w++; else phase = 3;
      end
      if (phase == 3) break;
      @(negedge clk);
    end
    startReq = 1'b0;
    chk(busy == 1'b0, "R3 busy low when run ends", busy, 0);
  endtask

  task automatic checkRun(input int hc, input int off, input int pw, input bit poke, input string tag);
    int h, o, w;
    holdCycles = CNT_W'(hc);
    pulseWidth = CNT_W'(pw);
    runMeasure(poke, h, o, w);
    chk(h == atLeastOne(hc), {"R2 hold length ", tag}, h, atLeastOne(hc));
    chk(o == atLeastOne(off), {"R3 offset length ", tag}, o, atLeastOne(off));
    chk(w == atLeastOne(pw), {"R3 pulse width ", tag}, w, atLeastOne(pw));
  endtask

  task automatic popEntry(output bit valid, output int g, output int ts);
    @(negedge clk);
    valid = fifoValid;
    g  = int'(fifoData[GW+TW-1:TW]);
    ts = int'(fifoData[TW-1:0]);
    fifoPop = 1'b1;
    @(negedge clk);
    fifoPop = 1'b0;
  endtask

  task automatic runSweep(input int st, input int sp, input int stp, input string tag);
    int expOff;
    bit expDone;
    int h, o, w;
    offsetStop = CNT_W'(sp);
    offsetStep = CNT_W'(stp);
    sweepEn = 1'b1;
    loadOffset(st);
    chk(curOffset == CNT_W'(st), {"R5 load ", tag}, curOffset, st);
    chk(sweepDone == 1'b0, {"R5 done cleared ", tag}, sweepDone, 0);
    expOff = st; expDone = 1'b0;
    holdCycles = 2; pulseWidth = 1;
    for (int k = 0; k < 12 && !expDone; k++) begin
      runMeasure(1'b0, h, o, w);
      chk(o == atLeastOne(expOff), {"R5 swept offset ", tag}, o, atLeastOne(expOff));
      if (expOff + stp > sp) expDone = 1'b1; else expOff = expOff + stp;
      @(negedge clk);
      chk(curOffset == CNT_W'(expOff), {"R5 next offset ", tag}, curOffset, expOff);
      chk(sweepDone == expDone, {"R5 done flag ", tag}, sweepDone, expDone);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int h, o, w, g, ts, cur, idx, base;
    bit valid, sawBusy;
    int drvIdx[DEPTH];
    int drvVal[12];
    void'($urandom(32'd1357));

    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(targetRstN == 1'b1, "R1 targetRstN", targetRstN, 1);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(sweepDone == 1'b0, "R1 sweepDone", sweepDone, 0);
    chk(fifoValid == 1'b0 && fifoFull == 1'b0, "R1 fifo empty", fifoValid, 0);
    chk(fifoOverflow == 1'b0, "R1 overflow", fifoOverflow, 0);

    // R2 R3 directed runs, including zero settings that collapse to one clock
    loadOffset(7);  checkRun(5, 7, 3, 1'b0, "5/7/3");
    loadOffset(0);  checkRun(0, 0, 0, 1'b0, "min");
    loadOffset(1);  checkRun(2, 1, 1, 1'b0, "2/1/1");
    // R6 start while busy ignored: same segment lengths with pokes
    loadOffset(6);  checkRun(10, 6, 2, 1'b1, "R6 poke during run");
    for (int k = 0; k < 6; k++) begin
      int rh, ro, rw;
      rh = int'($urandom % 31); ro = int'($urandom % 31); rw = int'($urandom % 11);
      loadOffset(ro);
      checkRun(rh, ro, rw, 1'b0, "random");
    end

    // R5 sweeps: one stopping short, one landing on the stop value
    runSweep(5, 8, 2, "5..8 step 2");
    // R6 start ignored while swept out
    sawBusy = 1'b0;
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    for (int k = 0; k < 6; k++) begin
      if (busy || !targetRstN) sawBusy = 1'b1;
      @(negedge clk);
    end
    chk(sawBusy == 1'b0, "R6 start ignored when sweep done", sawBusy, 0);
    runSweep(3, 5, 1, "3..5 step 1");
    sweepEn = 1'b0;

    // R7 button: bounces ignored, clean press starts, release ignored
    loadOffset(4);
    holdCycles = 3; pulseWidth = 1;
    sawBusy = 1'b0;
    for (int b = 0; b < 5; b++) begin
      buttonIn = 1'b1;
      repeat (6) begin @(negedge clk); if (busy) sawBusy = 1'b1; end
      buttonIn = 1'b0;
      repeat (4) begin @(negedge clk); if (busy) sawBusy = 1'b1; end
    end
    repeat (30) begin @(negedge clk); if (busy) sawBusy = 1'b1; end
    chk(sawBusy == 1'b0, "R7 bounces ignored", sawBusy, 0);
    buttonIn = 1'b1;
    idx = 0;
    for (int k = 1; k < 60; k++) begin
      @(negedge clk);
      if (!targetRstN) begin idx = k; break; end
    end
    chk(idx == DB + 3, "R7 press latency", idx, DB + 3);
    for (int k = 0; k < 60 && busy; k++) @(negedge clk);
    buttonIn = 1'b0;
    sawBusy = 1'b0;
    repeat (50) begin @(negedge clk); if (busy) sawBusy = 1'b1; end
    chk(sawBusy == 1'b0, "R7 release ignored", sawBusy, 0);

    // R4 R8 timestamps of pin changes inside a run
    loadOffset(20);
    holdCycles = 3; pulseWidth = 2;
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    for (int k = 0; k < 100 && !targetRstN; k++) @(negedge clk);
    repeat (4) @(negedge clk);
    gpioIn = 4'h5;
    repeat (7) @(negedge clk);
    gpioIn = 4'hA;
    for (int k = 0; k < 100 && busy; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    popEntry(valid, g, ts);
    chk(valid && g == 5, "R8 first entry gpio", g, 5);
    chk(ts == 6, "R4 R8 first timestamp", ts, 6);
    popEntry(valid, g, ts);
    chk(valid && g == 10, "R8 second entry gpio", g, 10);
    chk(ts == 13, "R4 R8 second timestamp", ts, 13);
    @(negedge clk);
    chk(fifoValid == 1'b0, "R9 empty after pops", fifoValid, 0);
    popEntry(valid, g, ts);
    @(negedge clk);
    chk(fifoValid == 1'b0 && fifoFull == 1'b0, "R9 pop on empty no effect", fifoValid, 0);

    // R8 R9 random spacing in free time
    cur = 10; idx = 0;
    for (int k = 0; k < 6; k++) begin
      int v, gap;
      v = int'($urandom % 16);
      if (v == cur) v = v ^ 1;
      gap = 1 + int'($urandom % 5);
      repeat (gap) @(negedge clk);
      idx += gap;
      gpioIn = GW'(v);
      drvIdx[k] = idx; drvVal[k] = v; cur = v;
    end
    repeat (4) @(negedge clk);
    base = 0;
    for (int k = 0; k < 6; k++) begin
      popEntry(valid, g, ts);
      if (k == 0) base = ts;
      chk(valid && g == drvVal[k], "R9 random order gpio", g, drvVal[k]);
      chk(ts - base == drvIdx[k] - drvIdx[0], "R8 random spacing", ts - base, drvIdx[k] - drvIdx[0]);
    end

    // R10 overflow: more changes than entries
    for (int k = 0; k < 12; k++) begin
      drvVal[k] = (cur + 1 + k) % 16;
      gpioIn = GW'(drvVal[k]);
      repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(fifoFull == 1'b1, "R10 full flag", fifoFull, 1);
    chk(fifoOverflow == 1'b1, "R10 overflow set", fifoOverflow, 1);
    for (int k = 0; k < DEPTH; k++) begin
      popEntry(valid, g, ts);
      chk(valid && g == drvVal[k], "R10 kept oldest entries", g, drvVal[k]);
    end
    @(negedge clk);
    chk(fifoValid == 1'b0, "R10 dropped entries absent", fifoValid, 0);
    chk(fifoOverflow == 1'b1, "R10 overflow sticky", fifoOverflow, 1);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule